// File: doc/BRIEF.md
# Orbit Trigger Generator

This block issues trigger-accept pulses against a repeating orbit of bunch crossings (3563 clocks by default). Triggers come from one of two sources. The pattern source places a programmable number of evenly spaced triggers in each orbit, starting at a programmable crossing. The pattern runs for a programmable number of orbits and can optionally start over after a repeat period. The random source compares a free-running 32-bit maximal-length shift-register sequence with a threshold. A falling edge on an external input adds exactly one candidate trigger.

Every candidate passes the same gates before it becomes a pulse on `trig_o`. Candidates in the gap at the end of the orbit are blanked. A downstream status other than Ready holds triggers back when back-pressure is enabled. Four sliding-window rate rules then apply, each allowing at most 1, 2, 3 or 4 triggers within its own number of crossings. A candidate refused by a rule is counted as a violation.

The block also drives an orbit marker that is three crossings wide. It keeps a running trigger count, which a capture strobe copies into the count output as one consistent snapshot.

Top module: `orbit_trig_gen`

## Requirements
- R1: The crossing index starts at 0 in the first cycle after reset, rises by one every clock and wraps from 3562 to 0. `orbit_mark_o` is high exactly while the index is 0, 1 or 2.
- R2: With `arm_i` high and `rand_mode_i` low, a candidate arises at crossings `first_bx_i + j*spacing_i` for j = 0 .. `per_orbit_i`-1, and `trig_o` pulses for one cycle in the cycle after each such crossing. With a spacing of 0 only the first slot exists, and a `per_orbit_i` of 0 gives no candidates.
- R3: With `burst_en_i` low, at most the first slot of an orbit produces a candidate, whatever the value of `per_orbit_i`.
- R4: Orbits are numbered from 0 after reset, and only orbits whose number is below `active_orbits_i` carry pattern triggers. With `repeat_en_i` high, the orbit number returns to 0 after `repeat_orbits_i` orbits. With it low, the number keeps counting upward and saturates.
- R5: With `rand_mode_i` high and `arm_i` high, a candidate arises in every cycle in which the internal random value is below `rand_thresh_i`. A threshold of 0 gives no candidates, and a threshold of all ones gives one in practically every cycle. A pulse on `new_rand_i` advances the sequence by one extra step.
- R6: Element k-1 of `rule_win_i` (k = 1..4) holds a window of N crossings. A candidate is suppressed if it would give more than k triggers within the current crossing and the N-1 before it. A window of 0 turns that rule off.
- R7: Every candidate suppressed by a rule increments `viol_count_o` by one.
- R8: With `bp_en_i` high, candidates are dropped while `status_i` differs from 4'b1000 (Ready). Such drops are not counted as violations. With `bp_en_i` low, the status has no effect.
- R9: Candidates at crossing index 3444 or above are dropped unless `no_blank_i` is high.
- R10: Each falling edge of `ext_trig_i` gives exactly one candidate, in the cycle in which the low level is first seen, independent of `arm_i`. A held low level gives nothing further.
- R11: On `capture_i`, `trig_count_o` takes, one cycle later, the number of `trig_o` pulses up to and including the capture cycle. Otherwise it holds its value.
- R12: During and right after reset, `trig_o` is 0, `orbit_mark_o` is 1, and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bunch crossing clock |
| rst_ni | input | 1 | active-low synchronous reset |
| arm_i | input | 1 | enables the pattern and random sources |
| rand_mode_i | input | 1 | 1 selects the random source, 0 the pattern |
| burst_en_i | input | 1 | allows more than one pattern slot per orbit |
| repeat_en_i | input | 1 | restarts the orbit numbering after the repeat period |
| bp_en_i | input | 1 | enables back-pressure gating |
| no_blank_i | input | 1 | turns off blanking of the orbit gap |
| first_bx_i | input | 12 | crossing of the first pattern slot |
| spacing_i | input | 12 | crossings between pattern slots |
| per_orbit_i | input | 8 | pattern slots per orbit |
| active_orbits_i | input | 16 | number of orbits that carry pattern triggers |
| repeat_orbits_i | input | 16 | repeat period in orbits |
| rand_thresh_i | input | 32 | random acceptance threshold |
| rule_win_i | input | 4x12 | window lengths of the four rate rules |
| new_rand_i | input | 1 | forces an extra random step |
| capture_i | input | 1 | snapshot strobe for the trigger count |
| status_i | input | 4 | downstream status state |
| ext_trig_i | input | 1 | external trigger, active on falling edge |
| trig_o | output | 1 | trigger-accept pulse |
| orbit_mark_o | output | 1 | three-crossing orbit marker |
| trig_count_o | output | 32 | captured trigger count |
| viol_count_o | output | 32 | rate-rule violation count |

## Verification
The hardest state to reach from the ports is a history of recent triggers dense enough to press one specific rule against its limit, while the other rules stay quiet. The stimulus gets there with a pattern of one slot per crossing for twenty crossings and only one rule window set at a time. This makes the allowed and refused candidates fall on crossings that can be counted by hand. The repeat behaviour needs three whole orbits before orbit numbering wraps, so that test runs for full orbits. Back-pressure is toggled in the middle of a pattern, so that refused slots fall between accepted ones.

// File: rtl/otg_pkg.sv
package otg_pkg;
    // status code meaning the downstream receiver can take triggers
    localparam logic [3:0] STATE_READY = 4'b1000;

    typedef enum logic {
        SRC_PATTERN = 1'b0,
        SRC_RANDOM  = 1'b1
    } src_sel_e;
endpackage

// File: rtl/otg_orbit_timer.sv
module otg_orbit_timer #(
    parameter int ORBIT_LEN = 3563,
    parameter int MARK_W    = 3,
    parameter int ORB_W     = 16,
    parameter int BX_W      = $clog2(ORBIT_LEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             repeat_en_i,
    input  logic [ORB_W-1:0] repeat_orbits_i,
    output logic [BX_W-1:0]  bx_o,
    output logic             start_o,
    output logic [ORB_W-1:0] orb_o,
    output logic             mark_o
);
    typedef struct packed {
        logic [BX_W-1:0]  bx;
        logic [ORB_W-1:0] orb;
        logic             mark;
    } tmr_t;

    tmr_t s_q, s_d;
    logic             wrap;
    logic [ORB_W:0]   orb_inc;

    always_comb begin
        s_d     = s_q;
        wrap    = (s_q.bx == BX_W'(ORBIT_LEN - 1));
        orb_inc = {1'b0, s_q.orb} + 1'b1;
        if (wrap) begin
            s_d.bx = '0;
            if (repeat_en_i && (orb_inc >= {1'b0, repeat_orbits_i})) begin
                s_d.orb = '0;
            end else if (s_q.orb != '1) begin
                s_d.orb = s_q.orb + 1'b1;
            end
        end else begin
            s_d.bx = s_q.bx + 1'b1;
        end
        s_d.mark = ({1'b0, s_d.bx} < (BX_W + 1)'(MARK_W));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{bx: '0, orb: '0, mark: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign bx_o    = s_q.bx;
    assign start_o = (s_q.bx == '0);
    assign orb_o   = s_q.orb;
    assign mark_o  = s_q.mark;

    // crossing index never leaves the orbit
    assert_bx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        {1'b0, s_q.bx} < (BX_W + 1)'(ORBIT_LEN));

    // marker drops exactly when the index reaches the marker width
    assert_mark_end_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(s_q.mark) |-> ({1'b0, s_q.bx} == (BX_W + 1)'(MARK_W)));
endmodule

// File: rtl/otg_pattern.sv
module otg_pattern #(
    parameter int BX_W  = 12,
    parameter int PER_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [BX_W-1:0]  bx_i,
    input  logic             start_i,
    input  logic             active_i,
    input  logic             burst_en_i,
    input  logic [BX_W-1:0]  first_i,
    input  logic [BX_W-1:0]  spacing_i,
    input  logic [PER_W-1:0] per_orbit_i,
    output logic             req_o
);
    typedef struct packed {
        logic [BX_W:0]    tgt;
        logic [PER_W-1:0] left;
    } pat_t;

    pat_t s_q, s_d;
    logic [PER_W-1:0] eff_per;
    logic [BX_W:0]    cur_tgt;
    logic [PER_W-1:0] cur_left;
    logic             hit;

    always_comb begin
        eff_per  = burst_en_i ? per_orbit_i : PER_W'(per_orbit_i != '0);
        cur_tgt  = start_i ? {1'b0, first_i} : s_q.tgt;
        cur_left = start_i ? eff_per : s_q.left;
        hit      = ({1'b0, bx_i} == cur_tgt) && (cur_left != '0);
        s_d.tgt  = hit ? (cur_tgt + {1'b0, spacing_i}) : cur_tgt;
        s_d.left = hit ? (cur_left - 1'b1) : cur_left;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{tgt: '0, left: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o = hit && active_i;

    // a slot never precedes the programmed first crossing (settings held within an orbit)
    assert_slot_after_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (bx_i >= first_i));
endmodule

// File: rtl/otg_lfsr.sv
module otg_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h0000_0001
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         extra_step_i,
    output logic [W-1:0] val_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } rnd_t;

    rnd_t s_q, s_d;
    logic [W-1:0] one_step;

    function automatic logic [W-1:0] advance(input logic [W-1:0] x);
        logic [W-1:0] y;
        y = x >> 1;
        if (x[0]) y = y ^ TAPS;
        return y;
    endfunction

    always_comb begin
        one_step = advance(s_q.sr);
        s_d.sr   = extra_step_i ? advance(one_step) : one_step;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.sr <= SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign val_o = s_q.sr;

    // a maximal-length sequence never enters the all-zero lock-up state
    assert_lfsr_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.sr != '0);
endmodule

// File: rtl/otg_rate_guard.sv
module otg_rate_guard #(
    parameter int NRULE = 4,
    parameter int AGE_W = 12,
    parameter int CNT_W = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        cand_i,
    input  logic [NRULE-1:0][AGE_W-1:0] win_i,
    output logic                        fire_o,
    output logic [CNT_W-1:0]            viol_o
);
    typedef struct packed {
        logic [NRULE-1:0][AGE_W-1:0] age;
        logic [CNT_W-1:0]            viol;
    } grd_t;

    grd_t s_q, s_d;
    logic [NRULE-1:0] blk;
    logic             refuse;

    // rule k+1 allows k+1 triggers: the (k+1)-th most recent one must be outside the window
    for (genvar k = 0; k < NRULE; k++) begin : g_rule
        assign blk[k] = (s_q.age[k] < win_i[k]);
    end

    assign refuse = |blk;
    assign fire_o = cand_i & ~refuse;

    function automatic logic [AGE_W-1:0] sat_inc(input logic [AGE_W-1:0] a);
        return (a == '1) ? a : a + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (fire_o) begin
            s_d.age[0] = AGE_W'(1);
            for (int i = 1; i < NRULE; i++) begin
                s_d.age[i] = sat_inc(s_q.age[i-1]);
            end
        end else begin
            for (int i = 0; i < NRULE; i++) begin
                s_d.age[i] = sat_inc(s_q.age[i]);
            end
        end
        s_d.viol = s_q.viol + CNT_W'(cand_i & refuse);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.age  <= '1;
            s_q.viol <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign viol_o = s_q.viol;

    // the violation count only moves after a refused candidate
    assert_viol_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.viol != $past(s_q.viol)) |-> ($past(cand_i) && !$past(fire_o)));
endmodule

// File: rtl/orbit_trig_gen.sv
module orbit_trig_gen
    import otg_pkg::*;
#(
    parameter int ORBIT_LEN = 3563,
    parameter int MARK_W    = 3,
    parameter int GAP_FIRST = 3444,
    parameter int ORB_W     = 16,
    parameter int PER_W     = 8,
    parameter int NRULE     = 4,
    parameter int CNT_W     = 32,
    parameter int RND_W     = 32,
    parameter int BX_W      = $clog2(ORBIT_LEN),
    parameter int AGE_W     = BX_W
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        arm_i,
    input  logic                        rand_mode_i,
    input  logic                        burst_en_i,
    input  logic                        repeat_en_i,
    input  logic                        bp_en_i,
    input  logic                        no_blank_i,
    input  logic [BX_W-1:0]             first_bx_i,
    input  logic [BX_W-1:0]             spacing_i,
    input  logic [PER_W-1:0]            per_orbit_i,
    input  logic [ORB_W-1:0]            active_orbits_i,
    input  logic [ORB_W-1:0]            repeat_orbits_i,
    input  logic [RND_W-1:0]            rand_thresh_i,
    input  logic [NRULE-1:0][AGE_W-1:0] rule_win_i,
    input  logic                        new_rand_i,
    input  logic                        capture_i,
    input  logic [3:0]                  status_i,
    input  logic                        ext_trig_i,
    output logic                        trig_o,
    output logic                        orbit_mark_o,
    output logic [CNT_W-1:0]            trig_count_o,
    output logic [CNT_W-1:0]            viol_count_o
);
    typedef struct packed {
        logic             ext;
        logic             trig;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] cap;
    } top_t;

    top_t s_q, s_d;

    logic [BX_W-1:0]  bx;
    logic             orbit_start;
    logic [ORB_W-1:0] orb;
    logic             orb_active;
    logic             pat_req;
    logic [RND_W-1:0] rnd_val;
    src_sel_e         src_sel;
    logic             src_req;
    logic             ext_fall;
    logic             cand_raw;
    logic             in_gap;
    logic             bp_hold;
    logic             cand;
    logic             fire;

    otg_orbit_timer #(
        .ORBIT_LEN(ORBIT_LEN), .MARK_W(MARK_W), .ORB_W(ORB_W), .BX_W(BX_W)
    ) u_timer (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .repeat_en_i    (repeat_en_i),
        .repeat_orbits_i(repeat_orbits_i),
        .bx_o           (bx),
        .start_o        (orbit_start),
        .orb_o          (orb),
        .mark_o         (orbit_mark_o)
    );

    assign orb_active = (orb < active_orbits_i);

    otg_pattern #(.BX_W(BX_W), .PER_W(PER_W)) u_pattern (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bx_i       (bx),
        .start_i    (orbit_start),
        .active_i   (orb_active),
        .burst_en_i (burst_en_i),
        .first_i    (first_bx_i),
        .spacing_i  (spacing_i),
        .per_orbit_i(per_orbit_i),
        .req_o      (pat_req)
    );

    otg_lfsr #(.W(RND_W)) u_lfsr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .extra_step_i(new_rand_i),
        .val_o       (rnd_val)
    );

    // candidate path: source select, external edge, gap blanking, back-pressure
    assign src_sel  = src_sel_e'(rand_mode_i);
    assign src_req  = (src_sel == SRC_RANDOM) ? (rnd_val < rand_thresh_i) : pat_req;
    assign ext_fall = s_q.ext & ~ext_trig_i;
    assign cand_raw = (arm_i & src_req) | ext_fall;
    assign in_gap   = (bx >= BX_W'(GAP_FIRST));
    assign bp_hold  = bp_en_i & (status_i != STATE_READY);
    assign cand     = cand_raw & (no_blank_i | ~in_gap) & ~bp_hold;

    otg_rate_guard #(.NRULE(NRULE), .AGE_W(AGE_W), .CNT_W(CNT_W)) u_guard (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .cand_i(cand),
        .win_i (rule_win_i),
        .fire_o(fire),
        .viol_o(viol_count_o)
    );

    always_comb begin
        s_d       = s_q;
        s_d.ext   = ext_trig_i;
        s_d.trig  = fire;
        s_d.count = s_q.count + CNT_W'(fire);
        if (capture_i) begin
            s_d.cap = s_q.count;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{ext: 1'b0, trig: 1'b0, count: '0, cap: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign trig_o       = s_q.trig;
    assign trig_count_o = s_q.cap;

    // no trigger leaves while back-pressure reports a non-Ready state
    assert_bp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.trig && $past(bp_en_i)) |-> ($past(status_i) == STATE_READY));

    // no trigger decided inside the orbit gap unless blanking is off
    assert_gap_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.trig && !$past(no_blank_i)) |-> ($past(bx) < BX_W'(GAP_FIRST)));

    // running count advances together with each pulse
    assert_count_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.trig |-> (s_q.count == $past(s_q.count) + 1'b1));

    // back-to-back pulses only when the single-trigger window is below two
    assert_rule_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.trig && $past(s_q.trig)) |-> ($past(rule_win_i[0]) < AGE_W'(2)));
endmodule

// File: tb/orbit_trig_gen_tb.sv
module orbit_trig_gen_tb;
    localparam int L   = 3563;
    localparam int GAP = 3444;

    typedef struct packed {
        int first;
        int sp;
        int per;
        bit burst;
        bit nb;
    } pv_t;

    localparam pv_t PVEC[6] = '{
        '{5,    100, 4, 1'b1, 1'b0},
        '{5,    100, 4, 1'b0, 1'b0},
        '{0,    1,   3, 1'b1, 1'b0},
        '{3400, 30,  5, 1'b1, 1'b0},
        '{3400, 30,  5, 1'b1, 1'b1},
        '{100,  10,  0, 1'b1, 1'b0}
    };

    typedef struct packed {
        int idx;
        int win;
        int pulses;
        int viol;
    } rv_t;

    localparam rv_t RVEC[4] = '{
        '{0, 4,  5,  15},
        '{1, 5,  8,  12},
        '{2, 10, 6,  14},
        '{3, 8,  12, 8}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        arm, rand_mode, burst, rpt, bp_en, nb;
    logic [11:0] first, sp;
    logic [7:0]  per;
    logic [15:0] act, rep;
    logic [31:0] thresh;
    logic [3:0][11:0] win;
    logic        new_rand, capture, ext;
    logic [3:0]  status;
    logic        trig, mark;
    logic [31:0] tcount, vcount;

    int n_chk = 0;
    int n_fail = 0;
    int k = 0;
    string vtag[6];

    always #4 clk = ~clk;

    orbit_trig_gen u_dut (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .rand_mode_i(rand_mode),
        .burst_en_i(burst), .repeat_en_i(rpt), .bp_en_i(bp_en), .no_blank_i(nb),
        .first_bx_i(first), .spacing_i(sp), .per_orbit_i(per),
        .active_orbits_i(act), .repeat_orbits_i(rep), .rand_thresh_i(thresh),
        .rule_win_i(win), .new_rand_i(new_rand), .capture_i(capture),
        .status_i(status), .ext_trig_i(ext), .trig_o(trig), .orbit_mark_o(mark),
        .trig_count_o(tcount), .viol_count_o(vcount)
    );

    task automatic chk(input string req, input longint act_v, input longint exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic defaults();
        arm = 1'b1; rand_mode = 1'b0; burst = 1'b0; rpt = 1'b0; bp_en = 1'b0; nb = 1'b0;
        first = '0; sp = '0; per = '0; act = 16'hFFFF; rep = '0; thresh = '0;
        win = '0; new_rand = 1'b0; capture = 1'b0; status = 4'b1000; ext = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        k++;
    endtask

    task automatic run_count(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (trig) pulses++;
        end
    endtask

    function automatic bit exp_hit(input int b, input pv_t v);
        int eff, d;
        eff = v.burst ? v.per : ((v.per > 0) ? 1 : 0);
        if (b < v.first) return 1'b0;
        d = b - v.first;
        if (v.sp == 0) begin
            if (d != 0) return 1'b0;
            if (eff < 1) return 1'b0;
        end else begin
            if ((d % v.sp) != 0) return 1'b0;
            if ((d / v.sp) >= eff) return 1'b0;
        end
        if (!v.nb && b >= GAP) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int p, mism, p0, p1, p2;
        vtag = '{"R2", "R3", "R2", "R9", "R9", "R2"};
        defaults();
        rst_n = 1'b0;

        // R12: reset state
        arm = 1'b0;
        do_reset();
        chk("R12 trig", trig, 0);
        chk("R12 mark", mark, 1);
        chk("R12 trig count", tcount, 0);
        chk("R12 viol count", vcount, 0);

        // R1: marker over one orbit and into the next
        mism = 0;
        for (int i = 1; i <= L + 6; i++) begin
            tick();
            if (mark !== (((k % L) < 3) ? 1'b1 : 1'b0)) mism++;
        end
        chk("R1 marker mismatches", mism, 0);

        // pattern vectors: placement, burst, blanking, empty
        for (int vi = 0; vi < 6; vi++) begin
            defaults();
            first = 12'(PVEC[vi].first);
            sp    = 12'(PVEC[vi].sp);
            per   = 8'(PVEC[vi].per);
            burst = PVEC[vi].burst;
            nb    = PVEC[vi].nb;
            do_reset();
            mism = 0;
            for (int i = 1; i <= L; i++) begin
                tick();
                if (trig !== exp_hit(k - 1, PVEC[vi])) mism++;
            end
            chk($sformatf("%s pattern vector %0d mismatches", vtag[vi], vi), mism, 0);
        end

        // R4: active orbits with and without repeat
        for (int r = 0; r < 2; r++) begin
            defaults();
            first = 12'd10; per = 8'd1; act = 16'd1; rep = 16'd2; rpt = (r == 0);
            do_reset();
            run_count(L, p0);
            run_count(L, p1);
            run_count(L, p2);
            chk("R4 orbit0 pulses", p0, 1);
            chk("R4 orbit1 pulses", p1, 0);
            chk("R4 orbit2 pulses", p2, (r == 0) ? 1 : 0);
        end

        // R6/R7: each rate rule alone
        for (int ri = 0; ri < 4; ri++) begin
            defaults();
            first = '0; sp = 12'd1; per = 8'd20; burst = 1'b1;
            win[RVEC[ri].idx] = 12'(RVEC[ri].win);
            do_reset();
            run_count(30, p);
            chk($sformatf("R6 rule %0d pulses", ri + 1), p, RVEC[ri].pulses);
            chk($sformatf("R7 rule %0d violations", ri + 1), vcount, RVEC[ri].viol);
        end

        // R8: back-pressure toggled mid-pattern
        defaults();
        first = 12'd5; sp = 12'd10; per = 8'd10; burst = 1'b1; bp_en = 1'b1;
        do_reset();
        p = 0;
        for (int i = 1; i <= 120; i++) begin
            tick();
            if (trig) p++;
            if (k == 40) status = 4'b0011;
            if (k == 60) status = 4'b1000;
        end
        chk("R8 pulses with back-pressure", p, 8);
        chk("R8 no violation counted", vcount, 0);
        defaults();
        first = 12'd5; sp = 12'd10; per = 8'd10; burst = 1'b1; status = 4'b0011;
        do_reset();
        run_count(120, p);
        chk("R8 status ignored when disabled", p, 10);

        // R10: external falling edge, arm low
        defaults();
        arm = 1'b0;
        do_reset();
        repeat (10) tick();
        ext = 1'b0;
        tick();
        chk("R10 pulse after edge", trig, 1);
        run_count(25, p);
        chk("R10 no further pulses while low", p, 0);
        ext = 1'b1;
        run_count(5, p);
        chk("R10 no pulse on rise", p, 0);

        // R11: capture snapshot
        defaults();
        first = '0; sp = 12'd1; per = 8'd20; burst = 1'b1;
        do_reset();
        run_count(10, p);
        chk("R11 ten pulses seen", p, 10);
        chk("R11 count held before capture", tcount, 0);
        capture = 1'b1;
        tick();
        capture = 1'b0;
        chk("R11 captured value", tcount, 10);
        repeat (19) tick();
        chk("R11 held after capture", tcount, 10);
        capture = 1'b1;
        tick();
        capture = 1'b0;
        chk("R11 second capture", tcount, 20);

        // R5: random source
        defaults();
        rand_mode = 1'b1; thresh = '0;
        do_reset();
        run_count(2000, p);
        chk("R5 zero threshold", p, 0);
        defaults();
        rand_mode = 1'b1; thresh = 32'hFFFF_FFFF; win[0] = 12'd7;
        do_reset();
        run_count(700, p);
        chk("R5 full threshold under rule", p, 100);
        defaults();
        rand_mode = 1'b1; thresh = 32'h8000_0000;
        do_reset();
        run_count(3000, p);
        n_chk++;
        if (p < 1200 || p > 1800) begin
            n_fail++;
            $display("FAIL R5 half threshold actual=%0d expected=1200..1800", p);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule